// File: doc/BRIEF.md
# Hidden CAS-before-RAS Refresh Sequencer

This block refreshes DRAM while the processor keeps running. No bus hold or hold-acknowledge exchange is used. A free-running interval timer raises a refresh request. The block then watches the processor's address-strobe and ready lines to find an idle gap between bus cycles. In that gap it runs one CAS-before-RAS refresh cycle on the processor clock. The strobes follow a fixed order:

- the address latch enable goes high;
- CAS, the refresh strobe and the low-memory select go low;
- RAS and the memory-read strobe pulse low;
- the strobes release;
- the latch enable falls.

During this cycle the 11-bit row counter drives the DRAM address bus.

A processor cycle may begin while the refresh is running. Cycles served by the cache finish normally. A cycle aimed at local memory or the expansion bus gets a stall indication for as long as the latch enable is high. Its first T-state may overlap the refresh, but its remaining states wait until the latch enable falls.

The block assumes the processor runs in non-pipelined mode.

Top module: `hidden_rfsh_top`

## Requirements
- R1: A pending refresh never starts while a processor bus cycle is open, meaning an address strobe (`cpu_ads_n` low) has been sampled and no ready (`cpu_ready_n` low) has been sampled since. After the ready is sampled at a clock edge, the refresh starts at the next edge, provided no new address strobe is present.
- R2: `addr_latch_en` rises at the edge where a refresh starts and stays high for the whole cycle. It is the last signal to return, so every strobe is inactive in its final high cycle.
- R3: Exactly two clocks after `addr_latch_en` rises, `rfsh_stb_n`, `lowmem_sel_n` and `cas_n` all go low on the same edge.
- R4: `CAS_RAS_CYC` (1) clocks after CAS falls, `ras_n` and `memrd_n` go low together. They stay low for `RAS_CYC` (3) clocks, then return high together.
- R5: While a refresh runs, `dram_we_n` is forced high regardless of `mc_we_n`, and this covers every cycle with `cas_n` low. Outside a refresh, `dram_we_n` follows `mc_we_n`.
- R6: `rfsh_stb_n`, `lowmem_sel_n` and `cas_n` return high `RECOV_CYC` (2) clocks after `memrd_n` rises. `addr_latch_en` falls `TAIL_CYC` (1) clock after that.
- R7: `row_addr` is 0 after reset and stays constant during a refresh. It increments by one at the edge where `addr_latch_en` falls, and wraps from 2047 to 0.
- R8: `cpu_stall` is high while `addr_latch_en` is high and a memory-targeted processor cycle is open or starting. A memory-targeted cycle is one whose `cpu_mem_sel` was high at its address strobe. `cpu_stall` drops on the edge where `addr_latch_en` falls.
- R9: The request timer counts `REQ_INTERVAL` clocks from reset. It then sets a single pending flag, so with the bus idle the first refresh starts at edge `REQ_INTERVAL`+1. The flag is held while the bus stays busy. However long the bus stays busy, it yields exactly one refresh once the bus becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_ads_n | input | 1 | Processor address strobe, active low |
| cpu_ready_n | input | 1 | Bus-cycle ready, active low |
| cpu_mem_sel | input | 1 | Cycle targets local memory or expansion bus (valid with address strobe) |
| mc_we_n | input | 1 | Write enable from the memory controller |
| addr_latch_en | output | 1 | Address latch enable, high across the refresh |
| rfsh_stb_n | output | 1 | Refresh strobe, active low |
| lowmem_sel_n | output | 1 | Low-memory chip select, active low |
| cas_n | output | 1 | DRAM column strobe |
| ras_n | output | 1 | DRAM row strobe |
| memrd_n | output | 1 | Memory-read strobe |
| dram_we_n | output | 1 | DRAM write enable, forced high during refresh |
| row_addr | output | 11 | Refresh row address |
| cpu_stall | output | 1 | Wait-state request for a colliding memory cycle |

## Verification
The assertions check four ordering properties on every clock:

- the refresh strobe and `cpu_stall` are only active under the latch enable;
- the write enable is high whenever CAS is low;
- RAS only falls while CAS is already low;
- the row address only ever steps by one.

They also check that a refresh never begins inside an open bus cycle, and that the pending flag survives until it is accepted. Only the bench's scenarios can show the following:

- the exact per-clock strobe spacing;
- the start one clock after a late ready;
- the single refresh after a long busy stretch;
- the moment the stall is released;
- the wrap of the row counter.

// File: rtl/hidden_rfsh_pkg.sv
package hidden_rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PRECHG,
    ST_ACTIVE,
    ST_RECOV,
    ST_TAIL
  } rf_state_e;
endpackage

// File: rtl/hidden_rfsh_timer.sv
module hidden_rfsh_timer #(
  parameter int INTERVAL = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic pending
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign tick = (cnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt     <= tick ? '0 : cnt + 1'b1;
      pending <= (pending & ~accept) | tick;
    end
  end

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !accept) |=> pending);
endmodule

// File: rtl/hidden_rfsh_gap.sv
module hidden_rfsh_gap (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ads_n,
  input  logic cpu_ready_n,
  input  logic cpu_mem_sel,
  output logic cyc_open,
  output logic mem_open,
  output logic gap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_open <= 1'b0;
      mem_open <= 1'b0;
    end else if (!cpu_ads_n) begin
      cyc_open <= 1'b1;
      mem_open <= cpu_mem_sel;
    end else if (!cpu_ready_n) begin
      cyc_open <= 1'b0;
      mem_open <= 1'b0;
    end
  end

  assign gap = !cyc_open && cpu_ads_n;

  // R8
  mem_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_open |-> cyc_open);
endmodule

// File: rtl/hidden_rfsh_seq.sv
module hidden_rfsh_seq
  import hidden_rfsh_pkg::*;
#(
  parameter int LEAD_CYC    = 2,
  parameter int CAS_RAS_CYC = 1,
  parameter int RAS_CYC     = 3,
  parameter int RECOV_CYC   = 2,
  parameter int TAIL_CYC    = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  output rf_state_e state,
  output logic      done
);
  localparam int TOTAL = LEAD_CYC + CAS_RAS_CYC + RAS_CYC + RECOV_CYC + TAIL_CYC;
  localparam int PH_W  = $clog2(TOTAL + 1);

  logic [PH_W-1:0] ph;

  function automatic logic [PH_W-1:0] span_m1(rf_state_e s);
    case (s)
      ST_LEAD:   return PH_W'(LEAD_CYC - 1);
      ST_PRECHG: return PH_W'(CAS_RAS_CYC - 1);
      ST_ACTIVE: return PH_W'(RAS_CYC - 1);
      ST_RECOV:  return PH_W'(RECOV_CYC - 1);
      ST_TAIL:   return PH_W'(TAIL_CYC - 1);
      default:   return '0;
    endcase
  endfunction

  function automatic rf_state_e succ(rf_state_e s);
    case (s)
      ST_LEAD:   return ST_PRECHG;
      ST_PRECHG: return ST_ACTIVE;
      ST_ACTIVE: return ST_RECOV;
      ST_RECOV:  return ST_TAIL;
      default:   return ST_IDLE;
    endcase
  endfunction

  assign done = (state == ST_TAIL) && (ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state <= ST_LEAD;
        ph    <= span_m1(ST_LEAD);
      end
    end else if (ph == '0) begin
      state <= succ(state);
      ph    <= span_m1(succ(state));
    end else begin
      ph <= ph - 1'b1;
    end
  end
endmodule

// File: rtl/hidden_rfsh_row.sv
module hidden_rfsh_row #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else if (step) row <= row + 1'b1;
  end

  // R7
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row) |-> (row == $past(row) + ROW_W'(1)));
endmodule

// File: rtl/hidden_rfsh_top.sv
module hidden_rfsh_top
  import hidden_rfsh_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int REQ_INTERVAL = 250,
  parameter int LEAD_CYC     = 2,
  parameter int CAS_RAS_CYC  = 1,
  parameter int RAS_CYC      = 3,
  parameter int RECOV_CYC    = 2,
  parameter int TAIL_CYC     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ads_n,
  input  logic             cpu_ready_n,
  input  logic             cpu_mem_sel,
  input  logic             mc_we_n,
  output logic             addr_latch_en,
  output logic             rfsh_stb_n,
  output logic             lowmem_sel_n,
  output logic             cas_n,
  output logic             ras_n,
  output logic             memrd_n,
  output logic             dram_we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             cpu_stall
);
  rf_state_e st;
  logic      pending, accept, done;
  logic      cyc_open, mem_open, gap;
  logic      strobe_phase;

  assign accept = (st == ST_IDLE) && pending && gap;

  hidden_rfsh_timer #(.INTERVAL(REQ_INTERVAL)) timer_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pending(pending));

  hidden_rfsh_gap gap_i (
    .clk(clk), .rst_n(rst_n), .cpu_ads_n(cpu_ads_n), .cpu_ready_n(cpu_ready_n),
    .cpu_mem_sel(cpu_mem_sel), .cyc_open(cyc_open), .mem_open(mem_open), .gap(gap));

  hidden_rfsh_seq #(
    .LEAD_CYC(LEAD_CYC), .CAS_RAS_CYC(CAS_RAS_CYC), .RAS_CYC(RAS_CYC),
    .RECOV_CYC(RECOV_CYC), .TAIL_CYC(TAIL_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .state(st), .done(done));

  hidden_rfsh_row #(.ROW_W(ROW_W)) row_i (
    .clk(clk), .rst_n(rst_n), .step(done), .row(row_addr));

  assign strobe_phase  = (st == ST_PRECHG) || (st == ST_ACTIVE) || (st == ST_RECOV);
  assign addr_latch_en = (st != ST_IDLE);
  assign rfsh_stb_n    = !strobe_phase;
  assign lowmem_sel_n  = !strobe_phase;
  assign cas_n         = !strobe_phase;
  assign ras_n         = (st != ST_ACTIVE);
  assign memrd_n       = (st != ST_ACTIVE);
  assign dram_we_n     = mc_we_n | addr_latch_en;
  assign cpu_stall     = addr_latch_en && (mem_open || (!cpu_ads_n && cpu_mem_sel));

  // R1
  start_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_latch_en) |-> !$past(cyc_open));
  // R2
  ref_under_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_stb_n |-> addr_latch_en);
  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n && !$past(cas_n));
  // R5
  we_high_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> dram_we_n);
  // R8
  stall_under_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> addr_latch_en);
endmodule

// File: tb/hidden_rfsh_top_tb_top.sv
module hidden_rfsh_top_tb_top;
  localparam int TB_INT = 16;
  localparam int ROW_W  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_ads_n = 1'b1, cpu_ready_n = 1'b1, cpu_mem_sel = 1'b0, mc_we_n = 1'b0;
  logic addr_latch_en, rfsh_stb_n, lowmem_sel_n, cas_n, ras_n, memrd_n, dram_we_n, cpu_stall;
  logic [ROW_W-1:0] row_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hidden_rfsh_top #(.ROW_W(ROW_W), .REQ_INTERVAL(TB_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_ads_n(cpu_ads_n), .cpu_ready_n(cpu_ready_n),
    .cpu_mem_sel(cpu_mem_sel), .mc_we_n(mc_we_n), .addr_latch_en(addr_latch_en),
    .rfsh_stb_n(rfsh_stb_n), .lowmem_sel_n(lowmem_sel_n), .cas_n(cas_n),
    .ras_n(ras_n), .memrd_n(memrd_n), .dram_we_n(dram_we_n),
    .row_addr(row_addr), .cpu_stall(cpu_stall));

  // per-cycle expectation after refresh start: {ale, ref/sel, cas, ras, memrd, we}
  localparam logic [5:0] EXP [10] = '{
    6'b111111, 6'b111111, 6'b100111, 6'b100001, 6'b100001,
    6'b100001, 6'b100111, 6'b100111, 6'b111111, 6'b011110};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [ROW_W-1:0] row0;
    int bad;
    repeat (3) @(negedge clk);
    // reset state (R2 R7 R8 R5)
    chk("R2 reset ale", addr_latch_en, 0);
    chk("R6 reset strobes", {rfsh_stb_n, lowmem_sel_n, cas_n, ras_n, memrd_n}, 5'b11111);
    chk("R7 reset row", row_addr, 0);
    chk("R8 reset stall", cpu_stall, 0);
    chk("R5 idle we follows", dram_we_n, 0);
    rst_n = 1'b1;

    // R9: first request at TB_INT, start at edge TB_INT+1
    repeat (TB_INT) step();
    chk("R9 no start before interval", addr_latch_en, 0);
    step();
    chk("R9 start after interval", addr_latch_en, 1);

    // table walk: R2 R3 R4 R5 R6, row held (R7)
    for (int t = 0; t < 10; t++) begin
      chk($sformatf("R2 ale t%0d", t), addr_latch_en, EXP[t][5]);
      chk($sformatf("R3 ref t%0d", t), rfsh_stb_n, EXP[t][4]);
      chk($sformatf("R3 lowmem t%0d", t), lowmem_sel_n, EXP[t][4]);
      chk($sformatf("R6 cas t%0d", t), cas_n, EXP[t][3]);
      chk($sformatf("R4 ras t%0d", t), ras_n, EXP[t][2]);
      chk($sformatf("R4 memrd t%0d", t), memrd_n, EXP[t][1]);
      chk($sformatf("R5 we t%0d", t), dram_we_n, EXP[t][0]);
      if (t < 9) chk($sformatf("R7 row held t%0d", t), row_addr, 0);
      if (t < 9) step();
    end
    chk("R7 row incremented", row_addr, 1);

    // R1: cache cycle opens and stays open across several intervals
    cpu_ads_n = 1'b0; cpu_mem_sel = 1'b0;
    step();
    cpu_ads_n = 1'b1;
    bad = 0;
    repeat (3 * TB_INT) begin
      step();
      if (addr_latch_en) bad++;
    end
    chk("R1 no refresh during open cycle", bad, 0);
    cpu_ready_n = 1'b0;
    step();
    cpu_ready_n = 1'b1;
    chk("R1 not yet at ready edge", addr_latch_en, 0);
    step();
    chk("R1 starts one edge after ready", addr_latch_en, 1);

    // R8: memory cycle starts during the refresh
    cpu_ads_n = 1'b0; cpu_mem_sel = 1'b1;
    #1;
    chk("R8 stall at strobe", cpu_stall, 1);
    step();
    cpu_ads_n = 1'b1;
    repeat (7) step();
    chk("R8 stall held while ale", cpu_stall, 1);
    chk("R2 ale still high t8", addr_latch_en, 1);
    step();
    chk("R8 stall released with ale", cpu_stall, 0);
    chk("R2 ale low t9", addr_latch_en, 0);
    chk("R7 row after second", row_addr, 2);

    // R9: long busy spell yields exactly one refresh, no second one queued
    bad = 0;
    repeat (2 * TB_INT) begin
      step();
      if (addr_latch_en) bad++;
    end
    chk("R9 no refresh while memory cycle open", bad, 0);
    chk("R9 row unchanged", row_addr, 2);
    cpu_ready_n = 1'b0;
    step();
    cpu_ready_n = 1'b1;
    step();
    chk("R9 held request runs", addr_latch_en, 1);
    cpu_ads_n = 1'b0; cpu_mem_sel = 1'b0;
    step();
    cpu_ads_n = 1'b1;
    repeat (8) step();
    chk("R9 one refresh done", row_addr, 3);
    repeat (3 * TB_INT) step();
    chk("R9 only one refresh from busy spell", row_addr, 3);
    cpu_ready_n = 1'b0;
    step();
    cpu_ready_n = 1'b1;

    // R7 wrap: idle bus, run until 2047 then one more refresh
    while (row_addr != 11'd2047) step();
    while (!addr_latch_en) step();
    row0 = row_addr;
    chk("R7 row at top", row0, 2047);
    while (addr_latch_en) step();
    chk("R7 wrap to zero", row_addr, 0);
    chk("R5 we follows after refresh", dram_we_n, 0);

    finish_run();
  end
endmodule